// File: doc/BRIEF.md
# Modem Frame Cipher Block Sequencer

This block links the symbol stream of a multicarrier modem to one block-cipher engine. A frame is 240 four-bit symbols, one for each used sub-channel, so 960 bits. The block takes symbols one at a time and places each in a block register. When a block is full it hands the block to the cipher engine. When the engine returns its result, the block sends the result back out as symbols, one per cycle. It then goes on with the next group of symbols until the whole frame has passed through.

Only one block is ever in flight, so a single engine serves the whole frame. The block width is a parameter, 64 or 128 bits. At 64 bits a frame splits into 15 full blocks. At 128 bits it splits into 8 blocks, and the eighth block holds only 16 real symbols. On the way in, the unused part of that last block is filled with zeros. On the way out, the matching part of the result is dropped. A one-cycle completion strobe marks the end of each frame, and new symbols are refused until it has fired.

Top module: `frame_cipher_seq`

## Requirements
- R1: After reset, sym_ready is 1 and cph_start, out_valid and frame_done are all 0.
- R2: Symbols are packed in arrival order. The first symbol of a block goes to bits [BLK_W-1:BLK_W-4] of cph_block, and each later symbol goes to the next lower 4-bit slot.
- R3: One frame makes ceil(240/(BLK_W/4)) cipher blocks: 8 blocks at BLK_W=128 and 15 at BLK_W=64. In the final block of a 128-bit frame, the 16 symbols fill bits [127:64] and bits [63:0] are zero.
- R4: cph_start is a single-cycle pulse, raised the cycle after a block's last symbol is accepted. cph_block stays unchanged from that pulse until cph_done is seen.
- R5: While a block waits for its result, sym_ready is 0 and no second cph_start is issued. A cph_done that arrives while no block is outstanding is ignored.
- R6: The cycle after cph_done, out_valid rises. The block then emits the result's valid symbols, most significant first, one per cycle. The padding symbols of the last 128-bit block are never emitted, so each frame gives exactly 240 outputs.
- R7: frame_done pulses for one cycle, in the cycle right after the frame's 240th output. sym_ready stays 0 from the last accepted symbol of a frame until that pulse.
- R8: sym_data is ignored whenever sym_valid is 0 or sym_ready is 0. Input gaps of any length are accepted.
- R9: Asserting rst_n in the middle of a frame throws away the symbols gathered so far. The next frame then starts from symbol 0 of block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sym_valid | input | 1 | An input symbol is offered |
| sym_data | input | 4 | Input symbol |
| sym_ready | output | 1 | The block accepts a symbol this cycle |
| cph_start | output | 1 | One-cycle request to the cipher engine |
| cph_block | output | BLK_W | Packed block for the cipher engine |
| cph_done | input | 1 | The cipher engine has a result |
| cph_result | input | BLK_W | Cipher engine result, sampled when cph_done is high |
| out_valid | output | 1 | An output symbol is present |
| out_data | output | 4 | Output symbol |
| frame_done | output | 1 | One-cycle end-of-frame strobe |

## Verification
The bench targets the short final 128-bit block. A design that counted it as full would emit 256 symbols and leak pad-derived values, and a design that failed to clear the pad would hand stale bits to the engine. Nibble order is checked against a position-dependent cipher model, so a byte- or slot-reversed packer produces mismatched outputs. Symbols are kept offered while the engine is busy and stray cph_done pulses are injected, which catches a design that swallows input or starts draining without a request. A reset in the middle of a frame follows, and it exposes any symbol or block counter that survives reset.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [2:0] {
    ST_FILL   = 3'd0,
    ST_LAUNCH = 3'd1,
    ST_WAIT   = 3'd2,
    ST_DRAIN  = 3'd3,
    ST_DONE   = 3'd4
  } fcs_state_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/fcs_packer.sv
module fcs_packer #(
  parameter int BLK_W = 128,
  parameter int NIB_W = 4,
  localparam int SLOTS = BLK_W / NIB_W,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [NIB_W-1:0] wr_nib,
  input  logic             clr,
  output logic [BLK_W-1:0] blk_o
);

  logic [BLK_W-1:0] blk_q;
  logic [BLK_W-1:0] blk_d;
  logic             blk_en;

  assign blk_en = wr_en | clr;

  always_comb begin
    blk_d = blk_q;
    if (clr) begin
      blk_d = '0;
    end
  end

  // Slot g holds the g-th symbol of the block, first symbol at the top.
  logic [BLK_W-1:0] slot_wr;
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_wr[BLK_W-1-g*NIB_W -: NIB_W] =
      (wr_en && (wr_idx == IDX_W'(g))) ? wr_nib : blk_d[BLK_W-1-g*NIB_W -: NIB_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
    end else if (blk_en) begin
      blk_q <= slot_wr;
    end
  end

  assign blk_o = blk_q;

  a_r4_no_write_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && clr));

endmodule

// File: rtl/fcs_unpacker.sv
module fcs_unpacker #(
  parameter int BLK_W = 128,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [BLK_W-1:0] ld_data,
  input  logic             shift,
  output logic [NIB_W-1:0] nib_o
);

  logic [BLK_W-1:0] sh_q;
  logic [BLK_W-1:0] sh_d;
  logic             sh_en;

  assign sh_en = ld | shift;

  always_comb begin
    sh_d = sh_q;
    if (ld) begin
      sh_d = ld_data;
    end else if (shift) begin
      sh_d = {sh_q[BLK_W-NIB_W-1:0], {NIB_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  assign nib_o = sh_q[BLK_W-1 -: NIB_W];

  a_r6_no_load_while_shifting: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld && shift));

endmodule

// File: rtl/fcs_sequencer.sv
module fcs_sequencer
  import fcs_pkg::*;
#(
  parameter int BLK_W      = 128,
  parameter int NIB_W      = 4,
  parameter int FRAME_NIBS = 240,
  localparam int SLOTS     = BLK_W / NIB_W,
  localparam int IDX_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int NUM_BLKS  = ceil_div(FRAME_NIBS, SLOTS),
  localparam int BLK_CW    = $clog2(NUM_BLKS + 1),
  localparam int LAST_NIBS = FRAME_NIBS - (NUM_BLKS - 1) * SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  input  logic             cph_done,
  output logic             sym_ready,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             clr,
  output logic             cph_start,
  output logic             ld,
  output logic             shift,
  output logic             out_valid,
  output logic             frame_done,
  output logic             last_blk
);

  localparam logic [IDX_W-1:0]  FULL_M1 = IDX_W'(SLOTS - 1);
  localparam logic [IDX_W-1:0]  LAST_M1 = IDX_W'(LAST_NIBS - 1);
  localparam logic [BLK_CW-1:0] BLK_M1  = BLK_CW'(NUM_BLKS - 1);

  fcs_state_e        st_q, st_d;
  logic [IDX_W-1:0]  nib_q, nib_d;
  logic [BLK_CW-1:0] blk_q, blk_d;
  logic              nib_lim;

  assign last_blk = (blk_q == BLK_M1);
  assign nib_lim  = (nib_q == (last_blk ? LAST_M1 : FULL_M1));

  always_comb begin
    st_d  = st_q;
    nib_d = nib_q;
    blk_d = blk_q;
    unique case (st_q)
      ST_FILL: begin
        if (sym_valid) begin
          if (nib_lim) begin
            nib_d = '0;
            st_d  = ST_LAUNCH;
          end else begin
            nib_d = nib_q + 1'b1;
          end
        end
      end
      ST_LAUNCH: st_d = ST_WAIT;
      ST_WAIT: begin
        if (cph_done) st_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (nib_lim) begin
          nib_d = '0;
          if (last_blk) begin
            blk_d = '0;
            st_d  = ST_DONE;
          end else begin
            blk_d = blk_q + 1'b1;
            st_d  = ST_FILL;
          end
        end else begin
          nib_d = nib_q + 1'b1;
        end
      end
      ST_DONE: st_d = ST_FILL;
      default: st_d = ST_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_FILL;
      nib_q <= '0;
      blk_q <= '0;
    end else begin
      st_q  <= st_d;
      nib_q <= nib_d;
      blk_q <= blk_d;
    end
  end

  assign sym_ready  = (st_q == ST_FILL);
  assign wr_en      = sym_ready && sym_valid;
  assign wr_idx     = nib_q;
  assign cph_start  = (st_q == ST_LAUNCH);
  assign ld         = (st_q == ST_WAIT) && cph_done;
  assign clr        = ld;
  assign shift      = (st_q == ST_DRAIN);
  assign out_valid  = shift;
  assign frame_done = (st_q == ST_DONE);

  a_r5_wait_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> !wr_en);

  a_r3_block_index_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    blk_q <= BLK_M1);

endmodule

// File: rtl/frame_cipher_seq.sv
module frame_cipher_seq #(
  parameter int BLK_W      = 128,
  parameter int NIB_W      = 4,
  parameter int FRAME_NIBS = 240
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  input  logic [NIB_W-1:0] sym_data,
  output logic             sym_ready,
  output logic             cph_start,
  output logic [BLK_W-1:0] cph_block,
  input  logic             cph_done,
  input  logic [BLK_W-1:0] cph_result,
  output logic             out_valid,
  output logic [NIB_W-1:0] out_data,
  output logic             frame_done
);

  localparam int SLOTS    = BLK_W / NIB_W;
  localparam int IDX_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int NUM_BLKS = fcs_pkg::ceil_div(FRAME_NIBS, SLOTS);
  localparam int PAD_BITS = (NUM_BLKS * SLOTS - FRAME_NIBS) * NIB_W;

  logic [1:0]       rst_sync;
  logic             rst_i_n;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             clr;
  logic             ld;
  logic             shift;
  logic             last_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync[1];

  fcs_sequencer #(
    .BLK_W(BLK_W), .NIB_W(NIB_W), .FRAME_NIBS(FRAME_NIBS)
  ) u_seq (
    .clk(clk), .rst_n(rst_i_n), .sym_valid(sym_valid), .cph_done(cph_done),
    .sym_ready(sym_ready), .wr_en(wr_en), .wr_idx(wr_idx), .clr(clr),
    .cph_start(cph_start), .ld(ld), .shift(shift), .out_valid(out_valid),
    .frame_done(frame_done), .last_blk(last_blk)
  );

  fcs_packer #(.BLK_W(BLK_W), .NIB_W(NIB_W)) u_pack (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_nib(sym_data), .clr(clr), .blk_o(cph_block)
  );

  fcs_unpacker #(.BLK_W(BLK_W), .NIB_W(NIB_W)) u_unpack (
    .clk(clk), .rst_n(rst_i_n), .ld(ld), .ld_data(cph_result),
    .shift(shift), .nib_o(out_data)
  );

  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_i_n)
    cph_start |=> (!cph_start && !sym_ready));

  a_r4_block_held: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($past(cph_start) && !$past(cph_done)) |-> $stable(cph_block));

  a_r6_drain_after_done: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(out_valid) |-> $past(cph_done));

  a_r7_done_after_output: assert property (@(posedge clk) disable iff (!rst_i_n)
    frame_done |-> ($past(out_valid) && !out_valid));

  a_r5_ready_output_exclusive: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(sym_ready && out_valid));

  if (PAD_BITS > 0) begin : g_pad
    a_r3_pad_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
      (cph_start && last_blk) |-> (cph_block[PAD_BITS-1:0] == '0));
  end

endmodule

// File: tb/frame_cipher_seq_test.sv
module frame_cipher_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int BW         = 128;
  localparam int NFR        = 240;
  localparam int NPB        = BW / 4;
  localparam int NB         = (NFR + NPB - 1) / NPB;
  localparam int PADB       = (NB * NPB - NFR) * 4;
  localparam int WDOG       = 150000;

  // seed, stride, cipher latency, input gap period (0 = none)
  localparam int NVEC = 4;
  localparam int VEC [NVEC][4] = '{
    '{3, 1, 5, 0},
    '{0, 7, 16, 3},
    '{15, 5, 1, 0},
    '{9, 11, 11, 2}
  };

  logic          clk;
  logic          rst_n;
  logic          sym_valid;
  logic [3:0]    sym_data;
  logic          sym_ready;
  logic          cph_start;
  logic [BW-1:0] cph_block;
  logic          cph_done;
  logic [BW-1:0] cph_result;
  logic          out_valid;
  logic [3:0]    out_data;
  logic          frame_done;

  int checks;
  int failures;
  int cyc;
  bit fed_all;
  logic [3:0] in_nib  [NFR];
  logic [3:0] exp_nib [NFR];

  frame_cipher_seq #(.BLK_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_data(sym_data),
    .sym_ready(sym_ready), .cph_start(cph_start), .cph_block(cph_block),
    .cph_done(cph_done), .cph_result(cph_result), .out_valid(out_valid),
    .out_data(out_data), .frame_done(frame_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [3:0] key_nib(input int j);
    return 4'((j * 7 + 5) & 15);
  endfunction

  function automatic logic [BW-1:0] key_blk();
    logic [BW-1:0] k;
    for (int j = 0; j < NPB; j++) k[BW-1-4*j -: 4] = key_nib(j);
    return k;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG);
      finish_run();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sym_valid = 1'b0;
    cph_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(input int seed, input int stride, input int lat, input int gap);
    int starts;
    for (int i = 0; i < NFR; i++) begin
      in_nib[i]  = 4'((seed + i * stride) & 15);
      exp_nib[i] = in_nib[i] ^ key_nib(i % NPB);
    end
    fed_all = 1'b0;
    starts = 0;
    fork
      begin : feeder
        int idx = 0;
        int t = 0;
        while (idx < NFR) begin
          @(negedge clk);
          t++;
          if (gap != 0 && (t % gap) == 0) begin
            sym_valid = 1'b0;
            sym_data  = 4'hA;
          end else begin
            sym_valid = 1'b1;
            sym_data  = in_nib[idx];
          end
          if (sym_valid && sym_ready) idx++;
        end
        @(negedge clk);
        sym_valid = 1'b0;
        fed_all = 1'b1;
      end
      begin : cipher
        for (int b = 0; b < NB; b++) begin
          logic [BW-1:0] cap;
          do @(negedge clk); while (!cph_start);
          cap = cph_block;
          if (b == 0) begin
            chk(cap[BW-1 -: 4] == in_nib[0], "R2 first slot", cap[BW-1 -: 4], in_nib[0]);
            chk(cap[BW-5 -: 4] == in_nib[1], "R2 second slot", cap[BW-5 -: 4], in_nib[1]);
          end
          if (b == NB - 1 && PADB > 0) begin
            chk(cap[PADB-1:0] == '0, "R3 pad zero", cap[PADB-1:0], 0);
            chk(cap[PADB+3 -: 4] == in_nib[NFR-1], "R3 last real slot",
                cap[PADB+3 -: 4], in_nib[NFR-1]);
          end
          for (int w = 0; w < lat; w++) begin
            @(negedge clk);
            chk(cph_block == cap, "R4 block held", cph_block[15:0], cap[15:0]);
            chk(!sym_ready && !cph_start, "R5 busy hold", {sym_ready, cph_start}, 0);
          end
          cph_result = cap ^ key_blk();
          cph_done = 1'b1;
          @(negedge clk);
          cph_done = 1'b0;
        end
      end
      begin : monitor
        int oidx = 0;
        bit got = 1'b0;
        while (!got) begin
          @(negedge clk);
          if (cph_start) starts++;
          if (out_valid) begin
            if (oidx < NFR)
              chk(out_data == exp_nib[oidx], "R6 output symbol", out_data, exp_nib[oidx]);
            else
              chk(1'b0, "R6 extra output", oidx, NFR - 1);
            oidx++;
          end
          if (fed_all && !frame_done)
            chk(!sym_ready, "R7 hold until frame end", sym_ready, 0);
          if (frame_done) begin
            got = 1'b1;
            chk(oidx == NFR, "R6 R7 outputs at frame end", oidx, NFR);
          end
        end
        @(negedge clk);
        chk(!frame_done && sym_ready, "R7 single strobe then ready",
            {frame_done, sym_ready}, 1);
      end
    join
    chk(starts == NB, "R3 block count", starts, NB);
  endtask

  initial begin
    checks = 0;
    failures = 0;
    cyc = 0;
    sym_valid = 1'b0;
    sym_data = 4'h0;
    cph_done = 1'b0;
    cph_result = '0;
    rst_n = 1'b0;
    fed_all = 1'b0;
    do_reset();

    // R1 reset state
    chk(sym_ready == 1'b1, "R1 sym_ready", sym_ready, 1);
    chk(cph_start == 1'b0, "R1 cph_start", cph_start, 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(frame_done == 1'b0, "R1 frame_done", frame_done, 0);

    // R5 stray cph_done while nothing is outstanding
    cph_result = '1;
    cph_done = 1'b1;
    @(negedge clk);
    cph_done = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!out_valid && sym_ready, "R5 stray done ignored", {out_valid, sym_ready}, 1);
    end

    // Table of frames: R2..R8
    for (int v = 0; v < NVEC; v++) begin
      run_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
    end

    // R8: symbols offered with sym_valid low leave no trace
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      sym_valid = 1'b0;
      sym_data = 4'hF;
    end
    run_frame(6, 3, 2, 0);

    // R9 reset in the middle of a frame
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      sym_valid = 1'b1;
      sym_data = 4'h5;
    end
    do_reset();
    chk(sym_ready && !out_valid, "R9 clean after mid-frame reset", {sym_ready, out_valid}, 2);
    run_frame(1, 13, 4, 0);

    finish_run();
  end

endmodule